// File: doc/BRIEF.md
# Nearest-Neighbor Coefficient Loader

This block fills a scaler's filter coefficient RAM so that the scaler behaves as a nearest-neighbor filter. The RAM is reached through two registers: an index register, which selects the word and carries an auto-increment enable, and a data register, which writes the selected word.

A single start pulse runs the whole load. First the index register is written with auto-increment switched on. Next, every packed coefficient word is streamed to the data register. Last, the index register is written back to zero. The table holds 17 phases of 7 taps each, which is 119 sixteen-bit coefficients packed two to a 32-bit word, so 60 data words in total.

Each write is placed on a simple register bus made of an address, data and a strobe. The block holds the write until the target raises ready.

Top module: `nn_coef_loader`

## Requirements
- R1: While reset is held and right after it, busy and the write strobe are low.
- R2: A start pulse received while idle raises busy on the next clock. The first write goes to the index address (0x00) with only bit 10, the auto-increment enable, set (data 0x0000_0400).
- R3: After the first index write, exactly 60 writes go to the data address (0x04). Data word w carries coefficient 2w in bits 15:0 and coefficient 2w+1 in bits 31:16.
- R4: The tap of coefficient i is i mod 7. Tap 3 is the center tap and has the value 0x0800. Every other tap has the value 0x3000.
- R5: The upper half of the last data word (word 59) is reserved and is written as zero.
- R6: The final write goes to the index address with data zero. Busy falls on the clock edge that completes this write.
- R7: While the strobe is high and ready is low, the strobe, address and data hold their values.
- R8: A start pulse while busy is ignored: the load in progress is not restarted, and no second load follows it.
- R9: One load produces exactly 62 completed writes, one for each cycle in which the strobe and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| start_i | input | 1 | One-cycle request to run a load |
| busy_o | output | 1 | High from the clock after start until the closing index write completes |
| wr_addr_o | output | 8 | Register address of the current write |
| wr_data_o | output | 32 | Register data of the current write |
| wr_strobe_o | output | 1 | A write is offered |
| wr_ready_i | input | 1 | The target accepts the offered write on this clock |

## Verification
The bench drives the loader into a model of the coefficient RAM that auto-increments its address. It then compares the stored table against a table computed from the tap rule. A packing that swaps the two halves, or that miscounts the mod-7 tap, shows up as wrong words at phase boundaries. A wrong value in the reserved half of word 59 is also caught.

Ready is stalled in a pseudo-random pattern, which exposes a design that advances its counter or changes data while a write is stalled. Such a design would skip or duplicate words. A start pulse issued in the middle of a load, and again near its end, catches a loader that restarts or chains a second burst. A missing closing index write would leave the model's index nonzero and auto-increment still on.

// File: rtl/nnl_pkg.sv
package nnl_pkg;

  // Load sequencer states; order is the order of writes on the bus.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_IDX_ON  = 2'd1,
    ST_DATA    = 2'd2,
    ST_IDX_OFF = 2'd3
  } nnl_state_e;

endpackage

// File: rtl/nnl_coef_gen.sv
// Builds one packed coefficient word from its word index.
module nnl_coef_gen #(
  parameter int                 PHASES     = 17,
  parameter int                 TAPS       = 7,
  parameter int                 CENTER_TAP = 3,
  parameter int                 COEF_W     = 16,
  parameter int                 WORD_W     = 32,
  parameter int                 CNT_W      = 6,
  parameter logic [COEF_W-1:0]  CENTER_VAL = 16'h0800,
  parameter logic [COEF_W-1:0]  SIDE_VAL   = 16'h3000
) (
  input  logic [CNT_W-1:0]  word_idx_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int LANES = WORD_W / COEF_W;
  localparam int TOTAL = PHASES * TAPS;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [31:0]       coef_idx;
    logic [31:0]       tap;
    logic [COEF_W-1:0] lane_val;

    always_comb begin
      coef_idx = {{(32-CNT_W){1'b0}}, word_idx_i} * LANES + l;
      tap      = coef_idx % TAPS;
      if (coef_idx >= TOTAL)
        lane_val = '0;              // reserved slot past the table end
      else if (tap == CENTER_TAP)
        lane_val = CENTER_VAL;
      else
        lane_val = SIDE_VAL;
    end

    assign word_o[l*COEF_W +: COEF_W] = lane_val;
  end

endmodule

// File: rtl/nnl_seq.sv
// Sequencer: index-on write, data burst, index-off write.
module nnl_seq
  import nnl_pkg::*;
#(
  parameter int WORDS = 60,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output nnl_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             xfer_o
);

  nnl_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;
  logic             xfer;

  assign xfer = (state_q != ST_IDLE) && ready_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_IDX_ON;
      ST_IDX_ON:  begin
                    state_d = ST_DATA;
                    cnt_d   = '0;
                  end
      ST_DATA:    if (cnt_q == CNT_W'(WORDS-1)) state_d = ST_IDX_OFF;
                  else                          cnt_d   = cnt_q + 1'b1;
      ST_IDX_OFF: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // Clock enable: a start in idle, or a completed write.
  assign en = ((state_q == ST_IDLE) && start_i) || xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign xfer_o  = xfer;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(WORDS)); // R3

  AST_DATA_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && !ready_i) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/nn_coef_loader.sv
module nn_coef_loader
  import nnl_pkg::*;
#(
  parameter int          PHASES      = 17,
  parameter int          TAPS        = 7,
  parameter int          CENTER_TAP  = 3,
  parameter int          COEF_W      = 16,
  parameter int          WORD_W      = 32,
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  INDEX_ADDR  = 8'h00,
  parameter logic [7:0]  DATA_ADDR   = 8'h04,
  parameter int          AUTOINC_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              wr_strobe_o,
  input  logic              wr_ready_i
);

  localparam int LANES = WORD_W / COEF_W;
  localparam int WORDS = (PHASES * TAPS + LANES - 1) / LANES;
  localparam int CNT_W = $clog2(WORDS);
  localparam logic [WORD_W-1:0] IDX_ON_VAL = WORD_W'(1) << AUTOINC_BIT;

  nnl_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             xfer;
  logic [WORD_W-1:0] coef_word;

  nnl_seq #(
    .WORDS (WORDS),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_i (wr_ready_i),
    .state_o (state),
    .cnt_o   (cnt),
    .xfer_o  (xfer)
  );

  nnl_coef_gen #(
    .PHASES     (PHASES),
    .TAPS       (TAPS),
    .CENTER_TAP (CENTER_TAP),
    .COEF_W     (COEF_W),
    .WORD_W     (WORD_W),
    .CNT_W      (CNT_W)
  ) u_gen (
    .word_idx_i (cnt),
    .word_o     (coef_word)
  );

  // Bus outputs decode from registered state only, so they hold while stalled.
  always_comb begin
    wr_addr_o = ADDR_W'(INDEX_ADDR);
    wr_data_o = '0;
    case (state)
      ST_IDX_ON: wr_data_o = IDX_ON_VAL;
      ST_DATA:   begin
                   wr_addr_o = ADDR_W'(DATA_ADDR);
                   wr_data_o = coef_word;
                 end
      default:   ;
    endcase
  end

  assign wr_strobe_o = (state != ST_IDLE);
  assign busy_o      = wr_strobe_o;

  AST_FIRST_IS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_strobe_o) |-> (wr_addr_o == ADDR_W'(INDEX_ADDR) && wr_data_o == IDX_ON_VAL)); // R2

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R2

  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe_o && !wr_ready_i) |=> (wr_strobe_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R7

  AST_CLOSE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(wr_addr_o) == ADDR_W'(INDEX_ADDR) && $past(wr_data_o) == '0 && $past(xfer))); // R6

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe_o && !wr_ready_i && start_i) |=> wr_strobe_o); // R8

endmodule

// File: tb/nn_coef_loader_tb.sv
module nnl_ram_model (
  input  logic        clk,
  input  logic        clear_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] data_i,
  input  logic        we_i,
  output logic [7:0]  idx_o,
  output logic        ainc_o
);
  logic [31:0] mem [64];
  logic [7:0]  idx;
  logic        ainc;

  always @(posedge clk) begin
    if (clear_i) begin
      for (int k = 0; k < 64; k++) mem[k] <= 32'hDEAD_BEEF;
      idx  <= 8'hFF;
      ainc <= 1'b0;
    end else if (we_i) begin
      if (addr_i == 8'h00) begin
        idx  <= {2'b00, data_i[5:0]};
        ainc <= data_i[10];
      end else if (addr_i == 8'h04) begin
        mem[idx[5:0]] <= data_i;
        if (ainc) idx <= idx + 8'd1;
      end
    end
  end
  assign idx_o  = idx;
  assign ainc_o = ainc;
endmodule

module nn_coef_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        busy_o;
  logic [7:0]  wr_addr_o;
  logic [31:0] wr_data_o;
  logic        wr_strobe_o;
  logic        wr_ready_i = 1'b1;
  logic        clear = 1'b0;
  logic [7:0]  m_idx;
  logic        m_ainc;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int xfer_n = 0;
  logic [7:0]  log_addr [64];
  logic [31:0] log_data [64];
  int          ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        prev_stall = 1'b0;
  logic [7:0]  prev_addr;
  logic [31:0] prev_data;

  always #2 clk = ~clk;   // 250 MHz

  nn_coef_loader u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_strobe_o(wr_strobe_o), .wr_ready_i(wr_ready_i)
  );

  nnl_ram_model u_ram (
    .clk(clk), .clear_i(clear), .addr_i(wr_addr_o), .data_i(wr_data_o),
    .we_i(wr_strobe_o && wr_ready_i), .idx_o(m_idx), .ainc_o(m_ainc)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] r;
    r = '0;
    for (int h = 0; h < 2; h++) begin
      int i = 2*w + h;
      if (i < 119) r[h*16 +: 16] = ((i % 7) == 3) ? 16'h0800 : 16'h3000;
    end
    return r;
  endfunction

  // Ready pattern, driven away from the active edge.
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready_i <= (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
  end

  // Bus monitor: logs completed writes and checks stall hold (R7).
  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (prev_stall) begin
        check(wr_strobe_o && wr_addr_o == prev_addr && wr_data_o == prev_data,
              "R7 hold under stall", wr_data_o, prev_data);
      end
      prev_stall = wr_strobe_o && !wr_ready_i;
      prev_addr  = wr_addr_o;
      prev_data  = wr_data_o;
      if (wr_strobe_o && wr_ready_i) begin
        if (xfer_n < 64) begin
          log_addr[xfer_n] = wr_addr_o;
          log_data[xfer_n] = wr_data_o;
        end
        xfer_n++;
      end
    end
  end

  // Watchdog
  initial begin
    wait (cycles > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic clear_ram();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    xfer_n = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic check_load(input string tag);
    check(xfer_n == 62, "R9 write count", xfer_n, 62);
    check(log_addr[0] == 8'h00 && log_data[0] == 32'h400, "R2 first index write", log_data[0], 32'h400);
    for (int w = 0; w < 60; w++) begin
      check(log_addr[w+1] == 8'h04, "R3 data address", {24'h0, log_addr[w+1]}, 32'h4);
      check(log_data[w+1] == exp_word(w), "R4 packed word", log_data[w+1], exp_word(w));
    end
    check(log_data[60][31:16] == 16'h0, "R5 reserved half", log_data[60], exp_word(59));
    check(log_addr[61] == 8'h00 && log_data[61] == 32'h0, "R6 closing index write", log_data[61], 0);
    check(m_idx == 8'h00 && m_ainc == 1'b0, "R6 index reset in RAM", {23'h0, m_ainc, m_idx}, 0);
    for (int w = 0; w < 60; w++)
      check(u_ram.mem[w] == exp_word(w), "R3 RAM content", u_ram.mem[w], exp_word(w));
    $display("scenario %s done", tag);
  endtask

  task automatic t_reset();
    check(!busy_o && !wr_strobe_o, "R1 reset state", {30'h0, busy_o, wr_strobe_o}, 0);
  endtask

  task automatic t_full_ready();
    ready_mode = 0;
    clear_ram();
    pulse_start();
    check(busy_o == 1'b1, "R2 busy after start", {31'h0, busy_o}, 1);
    check(wr_addr_o == 8'h00 && wr_data_o == 32'h400, "R2 first write offered", wr_data_o, 32'h400);
    wait_idle();
    check_load("full_ready");
  endtask

  task automatic t_stalled();
    ready_mode = 1;
    clear_ram();
    pulse_start();
    wait_idle();
    ready_mode = 0;
    check_load("stalled");
  endtask

  task automatic t_start_busy();
    ready_mode = 1;
    clear_ram();
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();                       // R8 ignored mid-load
    while (busy_o && xfer_n < 61) @(negedge clk);
    start_i = 1'b1;                      // R8 start near the end
    wait_idle();
    start_i = 1'b0;
    ready_mode = 0;
    repeat (5) @(negedge clk);
    check(!busy_o && !wr_strobe_o, "R8 no second load", {31'h0, busy_o}, 0);
    check_load("start_while_busy");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_ready();
    t_stalled();
    t_start_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule